// File: doc/BRIEF.md
# Triggered Conversion Sequencer with Pacer

This block paces and sequences the conversions of one data-converter channel. It does not move any data. It decides when a conversion happens and raises `sample_o` for one cycle each time. A mode input selects the behaviour:

- **Cleared:** nothing runs.
- **Held:** everything freezes where it is.
- **One run:** the block runs once and then parks in a done state.
- **Repeating:** the block runs and then arms itself again on its own.

When the mode first moves out of its power-on value, the block can wait for the converter's initialization handshake before it allows any conversion.

Three lines are taken from a shared clock-bus vector, each picked by its own index: the pacing source, the start trigger and the stop trigger. Each picked line is turned into a one-cycle event on its rising edge. After a start event, a down-counter counts pacing edges. Each time the counter reaches zero, a conversion is issued, which gives a rate of source/(1+divider). After a stop event, a programmed number of further conversions is issued, and then the run ends.

A 4-bit status code reports the phase. The live pacer count and a running total of conversions are also available for reading.

Top module: `conv_sequencer`

## Requirements
- R1: Status codes: 0x8 means the mode is uninitialized (0x4) and `init_req_i` is high. 0x0 means the mode is uninitialized and `init_req_i` is low, or the mode is reset (0x0) with initialization complete. While the reset pin is asserted, the block is in the same state as uninitialized mode.
- R2: In modes 0x4 and 0x0, all of the following hold after the next clock edge: the conversion count is 0, the sequencer is idle, the pacer count equals `div_i`, and no `sample_o` pulse occurs.
- R3: When the mode leaves 0x4 while `init_req_i` is high, status reads 0x9 until a clock edge samples `init_done_i` high. During that time `sample_o` stays low. When `init_req_i` is low, there is no initialization phase.
- R4: Mode 0x1 (paused) produces no sample. The sequencer phase, the pacer count and the conversion count all keep their values, and status shows the held phase.
- R5: Once initialization is complete, a run mode (0x2 one run, 0x3 repeating) moves the idle sequencer to status 0x2 (waiting for start). A start event moves it to 0x3 (converting). A stop event seen in 0x2 is ignored.
- R6: The pacer count is loaded with `div_i` outside states 0x3 and 0x4. In those states, each pacing event decrements the count, or, when the count is 0, raises `sample_o` in that same cycle and reloads `div_i`. With `div_i` = 0, every pacing event is a sample.
- R7: A stop event in state 0x3 leads to exactly `post_stop_i` further samples in state 0x4 (status 0x4). The run then ends. If `post_stop_i` is 0, the run ends at once.
- R8: In mode 0x2, the end of a run gives status 0x7. The block stays there, with no samples, until the mode becomes 0x0 or 0x4.
- R9: In mode 0x3, the end of a run gives status 0x5 for one cycle and then 0x2. The conversion count is not cleared.
- R10: The conversion count increments by one on each `sample_o` pulse. The pulse occurs only in states 0x3 and 0x4.
- R11: Each trigger acts on a rising edge only. A line held high gives a single event.
- R12: `pace_sel_i`, `start_sel_i` and `stop_sel_i` each choose the bit of `clk_bus_i` that acts as the corresponding trigger. Edges on other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Operating mode (0x0 reset, 0x1 pause, 0x2 one run, 0x3 repeat, 0x4 uninitialized) |
| init_req_i | input | 1 | Converter needs initialization |
| init_done_i | input | 1 | Converter initialization finished |
| clk_bus_i | input | BUS_W | Shared clock and trigger lines |
| pace_sel_i | input | SEL_W | Bus index of the pacing source |
| start_sel_i | input | SEL_W | Bus index of the start trigger |
| stop_sel_i | input | SEL_W | Bus index of the stop trigger |
| div_i | input | DIV_W | Pacer divider |
| post_stop_i | input | POST_W | Conversions to issue after the stop event |
| sample_o | output | 1 | One-cycle conversion strobe |
| status_o | output | 4 | Encoded phase |
| div_cnt_o | output | DIV_W | Live pacer count |
| conv_cnt_o | output | CNT_W | Total conversions since the last clear |

## Verification
`sample_o` is combinational within the cycle: it responds to a bus edge in the same cycle that the selected line rises. Status follows `mode_i` and `init_req_i` in that same cycle. The phase, the pacer count and the conversion count are registered and take their new values at the following clock edge.

The bench drives inputs at the falling edge and compares one nanosecond later. At that point the behavioural model has already computed the expected output for the current inputs from its state as of the previous rising edge. The model then advances its state with those same inputs, so every output is checked in the exact cycle it is due.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [3:0] {
    MODE_RESET  = 4'h0,
    MODE_PAUSE  = 4'h1,
    MODE_SINGLE = 4'h2,
    MODE_REARM  = 4'h3,
    MODE_UNINIT = 4'h4
  } mode_e;

  typedef enum logic [3:0] {
    ST_STOPPED    = 4'h0,
    ST_WAIT_START = 4'h2,
    ST_CONVERT    = 4'h3,
    ST_POST       = 4'h4,
    ST_REARM      = 4'h5,
    ST_DONE       = 4'h7,
    ST_NEED_INIT  = 4'h8,
    ST_INIT       = 4'h9
  } state_e;

  localparam int unsigned N_TRIG     = 3;
  localparam int unsigned TRIG_PACE  = 0;
  localparam int unsigned TRIG_START = 1;
  localparam int unsigned TRIG_STOP  = 2;
endpackage

// File: rtl/trig_edge.sv
module trig_edge #(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned SEL_W = $clog2(BUS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ev_o
);
  logic line, prev_q;

  assign line = bus_i[sel_i];
  assign ev_o = line & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= line;
  end

  // R11: two events in a row would mean a held line retriggered
  a_r11_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> !ev_o)
    else $error("a_r11_one_event");
endmodule

// File: rtl/pacer.sv
module pacer #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             fire_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;

  assign fire_o = en_i & tick_i & (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || load_i)   cnt_q <= div_i;
    else if (en_i && tick_i)    cnt_q <= fire_o ? div_i : cnt_q - DIV_W'(1);
  end

  a_r6_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q != '0 && !clr_i && !load_i)
      |=> cnt_q == $past(cnt_q) - DIV_W'(1))
    else $error("a_r6_countdown");

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(en_i && tick_i) && !clr_i && !load_i) |=> $stable(cnt_q))
    else $error("a_r6_hold");

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == $past(div_i))
    else $error("a_r2_load");
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int unsigned POST_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        mode_i,
  input  logic              init_req_i,
  input  logic              init_done_i,
  input  logic              start_ev_i,
  input  logic              stop_ev_i,
  input  logic              sample_i,
  input  logic [POST_W-1:0] post_stop_i,
  output logic              clear_o,
  output logic              run_o,
  output logic              active_o,
  output logic [3:0]        status_o,
  output logic [CNT_W-1:0]  conv_cnt_o
);
  localparam int unsigned PW1 = POST_W + 1;

  state_e            state_q, end_st;
  logic [POST_W-1:0] post_q;
  logic [CNT_W-1:0]  conv_q;
  logic              inited_q, ready, post_last;

  assign ready     = inited_q | ~init_req_i;
  assign clear_o   = (mode_i == MODE_UNINIT) || (mode_i == MODE_RESET);
  assign run_o     = ready && ((mode_i == MODE_SINGLE) || (mode_i == MODE_REARM));
  assign active_o  = (state_q == ST_CONVERT) || (state_q == ST_POST);
  assign end_st    = (mode_i == MODE_SINGLE) ? ST_DONE : ST_REARM;
  assign post_last = ({1'b0, post_q} + PW1'(1)) >= {1'b0, post_stop_i};
  assign conv_cnt_o = conv_q;

  always_comb begin
    if (mode_i == MODE_UNINIT)    status_o = init_req_i ? ST_NEED_INIT : ST_STOPPED;
    else if (!ready)              status_o = ST_INIT;
    else if (mode_i == MODE_RESET) status_o = ST_STOPPED;
    else                          status_o = state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            inited_q <= 1'b0;
    else if (mode_i == MODE_UNINIT)         inited_q <= 1'b0;
    else if (init_req_i && init_done_i)     inited_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STOPPED;
      post_q  <= '0;
      conv_q  <= '0;
    end else if (clear_o) begin
      state_q <= ST_STOPPED;
      post_q  <= '0;
      conv_q  <= '0;
    end else if (run_o) begin
      if (sample_i) conv_q <= conv_q + CNT_W'(1);
      case (state_q)
        ST_STOPPED:    state_q <= ST_WAIT_START;
        ST_WAIT_START: if (start_ev_i) state_q <= ST_CONVERT;
        ST_CONVERT: if (stop_ev_i) begin
          post_q  <= '0;
          state_q <= (post_stop_i == '0) ? end_st : ST_POST;
        end
        ST_POST: if (sample_i) begin
          if (post_last) state_q <= end_st;
          else           post_q  <= post_q + POST_W'(1);
        end
        ST_REARM:      state_q <= ST_WAIT_START;
        default:       state_q <= state_q;
      endcase
    end
  end

  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> (conv_q == '0) && (state_q == ST_STOPPED))
    else $error("a_r2_clear");

  a_r3_no_sample_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_INIT) |-> !sample_i)
    else $error("a_r3_no_sample_init");

  a_r4_pause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PAUSE) |=> $stable(conv_q) && $stable(state_q) && $stable(post_q))
    else $error("a_r4_pause_hold");

  a_r5_wait_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_START && run_o && !start_ev_i) |=> state_q == ST_WAIT_START)
    else $error("a_r5_wait_start");

  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !clear_o) |=> state_q == ST_DONE)
    else $error("a_r8_done_hold");

  a_r9_rearm_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REARM && !clear_o) |=> conv_q == $past(conv_q))
    else $error("a_r9_rearm_keep");

  a_r10_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !clear_o) |=> conv_q == $past(conv_q) + CNT_W'(1))
    else $error("a_r10_count_step");

  a_r10_sample_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> active_o)
    else $error("a_r10_sample_phase");
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned POST_W = 16,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned SEL_W = $clog2(BUS_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        mode_i,
  input  logic              init_req_i,
  input  logic              init_done_i,
  input  logic [BUS_W-1:0]  clk_bus_i,
  input  logic [SEL_W-1:0]  pace_sel_i,
  input  logic [SEL_W-1:0]  start_sel_i,
  input  logic [SEL_W-1:0]  stop_sel_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [POST_W-1:0] post_stop_i,
  output logic              sample_o,
  output logic [3:0]        status_o,
  output logic [DIV_W-1:0]  div_cnt_o,
  output logic [CNT_W-1:0]  conv_cnt_o
);
  logic [SEL_W-1:0]  sel [N_TRIG];
  logic [N_TRIG-1:0] ev;
  logic clear, run, active, fire;

  assign sel[TRIG_PACE]  = pace_sel_i;
  assign sel[TRIG_START] = start_sel_i;
  assign sel[TRIG_STOP]  = stop_sel_i;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
    trig_edge #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .bus_i (clk_bus_i),
      .sel_i (sel[g]),
      .ev_o  (ev[g])
    );
  end

  pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clear),
    .load_i(run & ~active),
    .en_i  (run & active),
    .tick_i(ev[TRIG_PACE]),
    .div_i (div_i),
    .fire_o(fire),
    .cnt_o (div_cnt_o)
  );

  seq_ctrl #(.POST_W(POST_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .init_req_i (init_req_i),
    .init_done_i(init_done_i),
    .start_ev_i (ev[TRIG_START]),
    .stop_ev_i  (ev[TRIG_STOP]),
    .sample_i   (fire),
    .post_stop_i(post_stop_i),
    .clear_o    (clear),
    .run_o      (run),
    .active_o   (active),
    .status_o   (status_o),
    .conv_cnt_o (conv_cnt_o)
  );

  assign sample_o = fire;

  a_r12_pace_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> clk_bus_i[pace_sel_i])
    else $error("a_r12_pace_select");
endmodule

// File: tb/conv_sequencer_test.sv
`timescale 1ns/100ps
module conv_sequencer_test;
  localparam int BUS_W = 16, SEL_W = 4, DIV_W = 16, POST_W = 16, CNT_W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_ni;
  logic [3:0]        mode;
  logic              init_req, init_done;
  logic [BUS_W-1:0]  bus;
  logic [SEL_W-1:0]  pace_sel, start_sel, stop_sel;
  logic [DIV_W-1:0]  div;
  logic [POST_W-1:0] post_stop;
  logic              sample_o;
  logic [3:0]        status_o;
  logic [DIV_W-1:0]  div_cnt_o;
  logic [CNT_W-1:0]  conv_cnt_o;

  conv_sequencer uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .init_req_i(init_req),
    .init_done_i(init_done), .clk_bus_i(bus), .pace_sel_i(pace_sel),
    .start_sel_i(start_sel), .stop_sel_i(stop_sel), .div_i(div),
    .post_stop_i(post_stop), .sample_o(sample_o), .status_o(status_o),
    .div_cnt_o(div_cnt_o), .conv_cnt_o(conv_cnt_o)
  );

  int vectors = 0, fails = 0;
  bit finished = 0;

  // behavioural model state
  int m_inited = 0, m_state = 0, m_post = 0, m_conv = 0, m_divc = 0;
  bit m_prev [3] = '{0, 0, 0};

  task automatic chk(bit ok, string req, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string st_tag(int s);
    case (s)
      8, 0:    return "R1 status";
      9:       return "R3 status";
      2, 3:    return "R5 status";
      4:       return "R7 status";
      7:       return "R8 status";
      5:       return "R9 status";
      default: return "R1 status";
    endcase
  endfunction

  task automatic step();
    bit ln [3], ev [3];
    bit ready, run, clear, smp, act;
    int est, endst;
    #1;
    ln[0] = bus[pace_sel]; ln[1] = bus[start_sel]; ln[2] = bus[stop_sel];
    for (int k = 0; k < 3; k++) ev[k] = ln[k] && !m_prev[k];
    ready = (m_inited != 0) || !init_req;
    clear = (mode == 4) || (mode == 0);
    run   = ready && (mode == 2 || mode == 3);
    act   = (m_state == 3) || (m_state == 4);
    if (mode == 4)      est = init_req ? 8 : 0;
    else if (!ready)    est = 9;
    else if (mode == 0) est = 0;
    else                est = m_state;
    smp = run && act && ev[0] && (m_divc == 0);
    chk(sample_o == smp, "R6 sample strobe", sample_o, smp);
    chk(status_o == est, st_tag(est), status_o, est);
    chk(div_cnt_o == m_divc, "R6 pacer count", div_cnt_o, m_divc);
    chk(conv_cnt_o == m_conv, "R10 conversion count", conv_cnt_o, m_conv);
    // advance
    endst = (mode == 2) ? 7 : 5;
    for (int k = 0; k < 3; k++) m_prev[k] = ln[k];
    if (mode == 4) m_inited = 0;
    else if (init_req && init_done) m_inited = 1;
    if (clear) begin
      m_state = 0; m_post = 0; m_conv = 0; m_divc = int'(div);
    end else if (run) begin
      if (smp) m_conv++;
      if (act) begin
        if (ev[0]) m_divc = (m_divc == 0) ? int'(div) : m_divc - 1;
      end else m_divc = int'(div);
      case (m_state)
        0: m_state = 2;
        2: if (ev[1]) m_state = 3;
        3: if (ev[2]) begin
             m_post = 0;
             m_state = (post_stop == 0) ? endst : 4;
           end
        4: if (smp) begin
             if (m_post + 1 >= int'(post_stop)) m_state = endst;
             else m_post++;
           end
        5: m_state = 2;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic pulse(int b);
    bus[b] = 1'b1; step();
    bus[b] = 1'b0; step();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    rst_ni = 0; mode = 4; init_req = 1; init_done = 0; bus = '0;
    pace_sel = 0; start_sel = 1; stop_sel = 2; div = 2; post_stop = 3;
    repeat (3) @(negedge clk);
    #1;
    chk(status_o == 8, "R1 reset state status", status_o, 8);
    chk(conv_cnt_o == 0, "R2 reset state count", conv_cnt_o, 0);
    chk(sample_o == 0, "R2 reset state strobe", sample_o, 0);
    @(negedge clk);
    rst_ni = 1;
    step(); step();
    mode = 2;
    repeat (3) step();
    pulse(0);
    chk(status_o == 9, "R3 initializing", status_o, 9);
    chk(conv_cnt_o == 0, "R3 no conversion while initializing", conv_cnt_o, 0);
    init_done = 1; step(); init_done = 0;
    step();
    pulse(2);
    chk(status_o == 2, "R5 stop ignored while waiting for start", status_o, 2);
    bus[1] = 1; repeat (4) step(); bus[1] = 0; step();
    chk(status_o == 3, "R11 start held high gives one event", status_o, 3);
    repeat (6) pulse(0);
    chk(conv_cnt_o == 2, "R6 one sample per three edges at divider 2", conv_cnt_o, 2);
    pulse(2);
    repeat (12) pulse(0);
    chk(status_o == 7, "R8 one-run ends done", status_o, 7);
    chk(conv_cnt_o == 5, "R7 three post-stop conversions", conv_cnt_o, 5);
    repeat (3) pulse(0);
    chk(conv_cnt_o == 5, "R8 no samples once done", conv_cnt_o, 5);
    mode = 0; step();
    chk(conv_cnt_o == 0, "R2 reset mode clears count", conv_cnt_o, 0);
    chk(status_o == 0, "R1 reset mode status", status_o, 0);
    mode = 3; div = 0; post_stop = 2; step(); step();
    pulse(1);
    repeat (3) pulse(0);
    mode = 1;
    repeat (4) pulse(0);
    chk(conv_cnt_o == 3, "R4 pause holds count", conv_cnt_o, 3);
    chk(status_o == 3, "R4 pause shows held phase", status_o, 3);
    mode = 3;
    pulse(2);
    repeat (2) pulse(0);
    chk(status_o == 2, "R9 re-armed and waiting", status_o, 2);
    chk(conv_cnt_o == 5, "R9 count kept across re-arm", conv_cnt_o, 5);
    start_sel = 5;
    pulse(1);
    chk(status_o == 2, "R12 unselected line ignored", status_o, 2);
    pulse(5);
    chk(status_o == 3, "R12 selected line starts", status_o, 3);
    mode = 4; init_req = 0; step();
    chk(status_o == 0, "R1 uninitialized without init need", status_o, 0);
    mode = 2; step(); step();
    chk(status_o == 2, "R3 no init phase when not required", status_o, 2);
    for (int i = 0; i < 4000; i++) begin
      if (i % 40 == 0) begin
        int r;
        r = $urandom % 10;
        mode = (r == 0) ? 4'h0 : (r == 1) ? 4'h1 : (r == 2) ? 4'h4 : ((r % 2) ? 4'h3 : 4'h2);
        pace_sel = SEL_W'($urandom); start_sel = SEL_W'($urandom);
        stop_sel = SEL_W'($urandom);
        div = DIV_W'($urandom % 4); post_stop = POST_W'($urandom % 4);
        init_req = ($urandom % 4) != 0;
      end
      bus = BUS_W'($urandom);
      init_done = ($urandom % 8) == 0;
      step();
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule